// File: doc/BRIEF.md
# Interrupt Event Register Group

This block collects up to seven event lines from a serial peripheral, latches or passes them into a status vector, masks that vector and drives one interrupt line. Software reaches it over a small 32-bit register bus. The mask is never written directly. One write-only port sets mask bits and another clears them. A read-only view returns the resulting mask. Status bits that come from events are sticky and are cleared by writing ones to them. Status bits that come from levels always show their source.

The same group also holds a one-bit controller enable and a transmit watermark level. Both are driven out as plain control pins. The bus request side is a valid/ready channel. `req_ready` is held high, so no request is ever stalled. A read returns `rsp_data` with `rsp_valid` one cycle after the request is accepted, and the response has no back-pressure. A write returns no response.

Top module: `intr_regfile`

## Requirements
- R1: After reset the mask, the sticky status bits and the controller enable are zero, the watermark level is 1, `irq` is low and `rsp_valid` is low.
- R2: A 1 on an event-type source bit (every bit not set in `LEVEL_MASK`, by default bits 0, 1, 2, 5 and 6) for one clock sets that status bit. The bit stays set after the source returns to 0.
- R3: A write to offset 0x04 clears each sticky status bit whose data bit is 1 and leaves the bits written 0 unchanged.
- R4: If a source event and a write-one-to-clear of the same sticky bit fall in the same cycle, the bit stays set.
- R5: A level-type status bit (set in `LEVEL_MASK`, by default bit 3 for transmit full and bit 4 for receive not empty) reads as its source in the cycle of the read, and writing 1 to it at 0x04 has no effect.
- R6: A write to offset 0x08 sets each mask bit whose data bit is 1. Zero data bits and data bits at or above bit 7 leave the mask unchanged.
- R7: A write to offset 0x0C clears each mask bit whose data bit is 1 and leaves the others unchanged.
- R8: `irq` is high exactly when some status bit and the same mask bit are both 1. A sticky event raises `irq` after the clock edge that latches it.
- R9: Offset 0x14 holds the controller enable in bit 0 and drives `ctl_en`. The upper bits are not stored and read as 0.
- R10: Offset 0x28 holds the transmit watermark, `WM_W` bits wide (default 8), and drives `wm_level`. Wider write data is truncated.
- R11: Reads of offsets 0x08 and 0x0C, of unmapped offsets, and of status or mask bits above bit 6 return 0. The mask is read at 0x10 and the status at 0x04.
- R12: `req_ready` is always 1. A read accepted at a clock edge gives `rsp_valid` high with its data for exactly the next cycle. A write gives no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request ready, always 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_data | output | DATA_W | Read data |
| ev_in | input | NSRC | Event and level sources, one per status bit |
| irq | output | 1 | Masked interrupt request |
| ctl_en | output | 1 | Controller enable |
| wm_level | output | WM_W | Transmit watermark level |

## Verification
The bench builds the block with its default parameters: seven sources, bits 3 and 4 as level-type, an 8-bit watermark and a 32-bit bus. With these values sticky and level bits sit side by side in one register, so a single clear write shows that it affects one kind and not the other. The narrow watermark lets a full-width write show the truncation. Upper write data bits reach the mask-set port, which shows that bits outside the seven sources are dropped.

// File: rtl/intr_regfile_pkg.sv
package intr_regfile_pkg;
  localparam int ADDR_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_STAT = 8'h04,
    OFS_SET  = 8'h08,
    OFS_CLR  = 8'h0C,
    OFS_MASK = 8'h10,
    OFS_CTL  = 8'h14,
    OFS_WMK  = 8'h28
  } reg_ofs_e;

  typedef struct packed {
    logic stat_w1c;
    logic mask_set;
    logic mask_clr;
    logic ctl_wr;
    logic wmk_wr;
  } wr_strobe_t;
endpackage

// File: rtl/intr_src_latch.sv
module intr_src_latch #(
  parameter int              NSRC       = 7,
  parameter logic [NSRC-1:0] LEVEL_MASK = 7'b0011000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] ev_in,
  input  logic            clr_stb,
  input  logic [NSRC-1:0] clr_bits,
  output logic [NSRC-1:0] status_view
);
  localparam logic [NSRC-1:0] STICKY_MASK = ~LEVEL_MASK;

  logic [NSRC-1:0] sticky_q;
  logic [NSRC-1:0] clr_eff;
  logic [NSRC-1:0] sticky_d;

  // a clear only reaches event-type bits; an event in the same cycle wins
  always_comb begin
    clr_eff  = clr_stb ? clr_bits : '0;
    sticky_d = ((sticky_q & ~clr_eff) | ev_in) & STICKY_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sticky_q <= '0;
    else        sticky_q <= sticky_d;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (LEVEL_MASK[i]) begin : g_level
      assign status_view[i] = ev_in[i];
    end else begin : g_sticky
      assign status_view[i] = sticky_q[i];
    end
  end
endmodule

// File: rtl/intr_mask_reg.sv
module intr_mask_reg #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_stb,
  input  logic            clr_stb,
  input  logic [NSRC-1:0] bits,
  output logic [NSRC-1:0] mask_q
);
  logic [NSRC-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (set_stb) mask_d = mask_d | bits;
    if (clr_stb) mask_d = mask_d & ~bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/intr_bus_slave.sv
module intr_bus_slave
  import intr_regfile_pkg::*;
#(
  parameter int NSRC   = 7,
  parameter int DATA_W = 32,
  parameter int WM_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [NSRC-1:0]   status_view,
  input  logic [NSRC-1:0]   mask_q,
  output wr_strobe_t        wstb,
  output logic [NSRC-1:0]   wbits,
  output logic              ctl_en,
  output logic [WM_W-1:0]   wm_level
);
  logic              acc_wr;
  logic              acc_rd;
  logic [DATA_W-1:0] rdata_d;
  logic              unused_wdata;

  assign req_ready    = 1'b1;
  assign acc_wr       = req_valid && req_ready && req_write;
  assign acc_rd       = req_valid && req_ready && !req_write;
  assign wbits        = req_wdata[NSRC-1:0];
  assign unused_wdata = ^req_wdata;

  always_comb begin
    wstb = '0;
    if (acc_wr) begin
      case (req_addr)
        OFS_STAT: wstb.stat_w1c = 1'b1;
        OFS_SET:  wstb.mask_set = 1'b1;
        OFS_CLR:  wstb.mask_clr = 1'b1;
        OFS_CTL:  wstb.ctl_wr   = 1'b1;
        OFS_WMK:  wstb.wmk_wr   = 1'b1;
        default:  wstb = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      wm_level <= WM_W'(1);
    end else begin
      if (wstb.ctl_wr) ctl_en   <= req_wdata[0];
      if (wstb.wmk_wr) wm_level <= req_wdata[WM_W-1:0];
    end
  end

  always_comb begin
    case (req_addr)
      OFS_STAT: rdata_d = DATA_W'(status_view);
      OFS_MASK: rdata_d = DATA_W'(mask_q);
      OFS_CTL:  rdata_d = DATA_W'(ctl_en);
      OFS_WMK:  rdata_d = DATA_W'(wm_level);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_rd;
      if (acc_rd) rsp_data <= rdata_d;
    end
  end
endmodule

// File: rtl/intr_regfile.sv
module intr_regfile
  import intr_regfile_pkg::*;
#(
  parameter int              NSRC       = 7,
  parameter int              DATA_W     = 32,
  parameter int              WM_W       = 8,
  parameter logic [NSRC-1:0] LEVEL_MASK = 7'b0011000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  input  logic [NSRC-1:0]   ev_in,
  output logic              irq,
  output logic              ctl_en,
  output logic [WM_W-1:0]   wm_level
);
  wr_strobe_t      wstb;
  logic [NSRC-1:0] wbits;
  logic [NSRC-1:0] status_view;
  logic [NSRC-1:0] mask_q;

  intr_bus_slave #(.NSRC(NSRC), .DATA_W(DATA_W), .WM_W(WM_W)) u_bus (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .status_view (status_view),
    .mask_q      (mask_q),
    .wstb        (wstb),
    .wbits       (wbits),
    .ctl_en      (ctl_en),
    .wm_level    (wm_level)
  );

  intr_src_latch #(.NSRC(NSRC), .LEVEL_MASK(LEVEL_MASK)) u_src (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_in       (ev_in),
    .clr_stb     (wstb.stat_w1c),
    .clr_bits    (wbits),
    .status_view (status_view)
  );

  intr_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (wstb.mask_set),
    .clr_stb (wstb.mask_clr),
    .bits    (wbits),
    .mask_q  (mask_q)
  );

  assign irq = |(status_view & mask_q);
endmodule

// File: rtl/intr_regfile_chk.sv
module intr_regfile_chk #(
  parameter int              NSRC       = 7,
  parameter int              DATA_W     = 32,
  parameter logic [NSRC-1:0] LEVEL_MASK = 7'b0011000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [7:0]        req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic [NSRC-1:0]   ev_in,
  input logic              irq,
  input logic              rsp_valid,
  input logic [NSRC-1:0]   status_view,
  input logic [NSRC-1:0]   mask_q
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2 (and R4: a same-cycle clear cannot drop a fresh event)
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((($past(ev_in) & ~LEVEL_MASK) & ~status_view) == '0));

  // R6
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h08) |=>
      ((mask_q & $past(req_wdata[NSRC-1:0])) == $past(req_wdata[NSRC-1:0])));

  // R7
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 8'h0C) |=>
      ((mask_q & $past(req_wdata[NSRC-1:0])) == '0));

  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));

  // R8
  irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_view == '0) |-> !irq);

  // R12
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  // R12
  rsp_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !(req_valid && !req_write)) |=> !rsp_valid);
endmodule

bind intr_regfile intr_regfile_chk #(
  .NSRC(NSRC), .DATA_W(DATA_W), .LEVEL_MASK(LEVEL_MASK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_wdata   (req_wdata),
  .ev_in       (ev_in),
  .irq         (irq),
  .rsp_valid   (rsp_valid),
  .status_view (status_view),
  .mask_q      (mask_q)
);

// File: tb/intr_regfile_test.sv
module intr_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 27;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [6:0]  ev_in = '0;
  logic        irq;
  logic        ctl_en;
  logic [7:0]  wm_level;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_regfile uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ev_in(ev_in), .irq(irq),
    .ctl_en(ctl_en), .wm_level(wm_level)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [6:0]  ev;
    logic [31:0] exp;
    logic        exp_irq;
    logic [3:0]  rq;
  } vec_t;

  // wr, addr, wdata, ev, expected read data, expected irq, requirement
  localparam logic [84:0] VEC [NVEC] = '{
    {1'b1, 8'h08, 32'h0000_0002, 7'h00, 32'h0, 1'b0, 4'd6},   // R6 enable bit 1
    {1'b0, 8'h10, 32'h0,         7'h00, 32'h2, 1'b0, 4'd6},   // R6 mask view
    {1'b0, 8'h04, 32'h0,         7'h02, 32'h0, 1'b1, 4'd8},   // R8 event raises irq
    {1'b0, 8'h04, 32'h0,         7'h00, 32'h2, 1'b1, 4'd2},   // R2 sticky
    {1'b1, 8'h04, 32'h0000_0001, 7'h00, 32'h0, 1'b1, 4'd3},   // R3 zero bit keeps
    {1'b0, 8'h04, 32'h0,         7'h00, 32'h2, 1'b1, 4'd3},
    {1'b1, 8'h04, 32'h0000_0002, 7'h02, 32'h0, 1'b1, 4'd4},   // R4 collision
    {1'b0, 8'h04, 32'h0,         7'h00, 32'h2, 1'b1, 4'd4},
    {1'b1, 8'h04, 32'h0000_0002, 7'h00, 32'h0, 1'b0, 4'd3},   // R3 clear
    {1'b0, 8'h04, 32'h0,         7'h00, 32'h0, 1'b0, 4'd3},
    {1'b0, 8'h04, 32'h0,         7'h10, 32'h10, 1'b0, 4'd5},  // R5 level live
    {1'b1, 8'h08, 32'h0000_0010, 7'h10, 32'h0, 1'b1, 4'd8},
    {1'b1, 8'h04, 32'h0000_0010, 7'h10, 32'h0, 1'b1, 4'd5},   // R5 clear ignored
    {1'b0, 8'h04, 32'h0,         7'h10, 32'h10, 1'b1, 4'd5},
    {1'b0, 8'h04, 32'h0,         7'h00, 32'h0, 1'b0, 4'd5},
    {1'b0, 8'h10, 32'h0,         7'h00, 32'h12, 1'b0, 4'd6},
    {1'b1, 8'h0C, 32'h0000_0002, 7'h00, 32'h0, 1'b0, 4'd7},   // R7
    {1'b0, 8'h10, 32'h0,         7'h00, 32'h10, 1'b0, 4'd7},
    {1'b0, 8'h08, 32'h0,         7'h00, 32'h0, 1'b0, 4'd11},  // R11
    {1'b0, 8'h0C, 32'h0,         7'h00, 32'h0, 1'b0, 4'd11},
    {1'b1, 8'h14, 32'hFFFF_FFFF, 7'h00, 32'h0, 1'b0, 4'd9},   // R9
    {1'b0, 8'h14, 32'h0,         7'h00, 32'h1, 1'b0, 4'd9},
    {1'b0, 8'h28, 32'h0,         7'h00, 32'h1, 1'b0, 4'd10},  // R10
    {1'b1, 8'h28, 32'hFFFF_FFA5, 7'h00, 32'h0, 1'b0, 4'd10},
    {1'b0, 8'h28, 32'h0,         7'h00, 32'hA5, 1'b0, 4'd10},
    {1'b0, 8'h18, 32'h0,         7'h00, 32'h0, 1'b0, 4'd11},
    {1'b0, 8'h04, 32'h0,         7'h08, 32'h8, 1'b0, 4'd5}
  };

  task automatic check(input int rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic do_op(input logic wr, input logic [7:0] addr,
                       input logic [31:0] data, input logic [6:0] ev,
                       output logic [31:0] rd, output logic rv,
                       output logic iq);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = addr;
    req_wdata = data;
    ev_in     = ev;
    @(negedge clk);
    rd = rsp_data;
    rv = rsp_valid;
    iq = irq;
    req_valid = 1'b0;
    ev_in     = '0;
  endtask

  task automatic rd_chk(input logic [7:0] addr, input logic [6:0] ev,
                        input logic [31:0] exp, input int rq);
    logic [31:0] rd;
    logic rv, iq;
    do_op(1'b0, addr, 32'h0, ev, rd, rv, iq);
    check(rq, "read data", rd, exp);
  endtask

  task automatic wr_op(input logic [7:0] addr, input logic [31:0] data);
    logic [31:0] rd;
    logic rv, iq;
    do_op(1'b1, addr, data, 7'h00, rd, rv, iq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic rv, iq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(1, "irq", 32'(irq), 32'h0);
    check(1, "ctl_en", 32'(ctl_en), 32'h0);
    check(1, "wm_level", 32'(wm_level), 32'h1);
    check(1, "rsp_valid", 32'(rsp_valid), 32'h0);
    check(12, "req_ready", 32'(req_ready), 32'h1);   // R12
    rd_chk(8'h10, 7'h00, 32'h0, 1);
    rd_chk(8'h04, 7'h00, 32'h0, 1);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = vec_t'(VEC[i]);
      do_op(v.wr, v.addr, v.data, v.ev, rd, rv, iq);
      check(int'(v.rq), "irq", 32'(iq), 32'(v.exp_irq));
      check(12, "rsp_valid", 32'(rv), 32'(!v.wr));     // R12
      if (!v.wr) check(int'(v.rq), "read data", rd, v.exp);
    end

    // R9 / R10 output pins
    check(9, "ctl_en", 32'(ctl_en), 32'h1);
    check(10, "wm_level", 32'(wm_level), 32'hA5);
    wr_op(8'h14, 32'hFFFF_FFFE);
    check(9, "ctl_en off", 32'(ctl_en), 32'h0);
    rd_chk(8'h14, 7'h00, 32'h0, 9);

    // R6 bits above the sources are dropped
    wr_op(8'h08, 32'hFFFF_FF80);
    rd_chk(8'h10, 7'h00, 32'h10, 6);

    // R2 several sticky bits at once, R3 clear them all
    wr_op(8'h08, 32'h0000_007F);
    rd_chk(8'h04, 7'h61, 32'h0, 2);
    check(8, "irq multi", 32'(irq), 32'h1);
    rd_chk(8'h04, 7'h00, 32'h61, 2);
    wr_op(8'h04, 32'h0000_007F);
    check(3, "irq after clear", 32'(irq), 32'h0);
    rd_chk(8'h04, 7'h00, 32'h0, 3);

    // R11 upper status bits stay zero with all sources high
    rd_chk(8'h04, 7'h7F, 32'h18, 11);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule